// File: doc/BRIEF.md
# Shared-Address Serial Configuration Register

This block is the register slice that sits between a simple peripheral bus and a serial port. One bus address holds two physical registers. The first is a seven-field frame-format control register. The second is the upper nibble of the baud-rate divisor. On a write, the most significant data bit picks the register that is updated. If it is set, the control register takes the write; if it is clear, the divisor nibble does. On a read of the same address, the block returns the control register unless a divisor-read qualifier input is held, in which case it returns the divisor nibble.

The control register fields leave the block as decoded configuration outputs for the serial engines: line mode, parity mode with enable and odd/even flags, stop-bit count, character-size low bits and clock polarity. A third character-size bit is kept in another register and arrives on an input. From the resulting three-bit code the block derives a data-bit count. Reserved codes fall back to eight bits and raise an error flag.

A small access state machine classifies every bus cycle. The states are ST_IDLE, ST_WR_CTRL, ST_WR_DIV, ST_RD_CTRL, ST_RD_DIV and ST_WR_RD. Each bus cycle moves the machine to one of these states. An address miss leads to ST_IDLE. A matching write with the select bit set leads to ST_WR_CTRL, and one with the select bit clear leads to ST_WR_DIV. A matching read leads to ST_RD_DIV when the qualifier is held and to ST_RD_CTRL otherwise. A matching write and read in the same cycle lead to ST_WR_RD. The read-valid output is high in the three read-bearing states.

Top module: `scfg_shared_reg`

## Requirements
- R1: A write to the shared address with bus_wdata[7]=1 loads the control register from bus_wdata[6:0] with this field order: bit 6 mode (1 = synchronous), bits 5:4 parity mode, bit 3 two-stop select, bits 2:1 size low bits, bit 0 clock polarity. The divisor nibble is left unchanged. The new fields appear on the outputs one cycle after the write strobe.
- R2: A write to the shared address with bus_wdata[7]=0 loads div_hi from bus_wdata[3:0] and drops bits 6:4. It leaves every control output unchanged.
- R3: After reset the control fields are all zero except the size low bits, which are 11, and div_hi is zero. A control read then returns 0x86, and bus_rvalid is low.
- R4: A read of the shared address with div_rd_qual=0 returns {1, control fields} on bus_rdata, and bus_rvalid is high in the cycle after the strobe. Bit 7 always reads as one.
- R5: A read of the shared address with div_rd_qual=1 returns the divisor nibble in the low bits, with every upper bit zero.
- R6: A write or read to any other address changes no register and raises no bus_rvalid.
- R7: The size code {size_hi, size_lo} maps 000, 001, 010, 011 and 111 to 5, 6, 7, 8 and 9 data bits, with cfg_error low.
- R8: Size codes 100, 101 and 110 give cfg_data_bits = 8 and cfg_error = 1.
- R9: Parity mode 00 disables parity, 10 selects even and 11 selects odd. The reserved 01 reports cfg_parity_en = 0 and cfg_parity_odd = 0.
- R10: A write and a read to the shared address in the same cycle are both performed. The read returns the contents from before the write, and the write takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W | Bus address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data; bit 7 selects the target register |
| div_rd_qual | input | 1 | Read returns the divisor nibble instead of control |
| size_hi | input | 1 | Character-size high bit held elsewhere |
| bus_rdata | output | 8 | Registered read data |
| bus_rvalid | output | 1 | Read data valid, one cycle after the read strobe |
| cfg_sync_mode | output | 1 | 1 = synchronous line mode |
| cfg_parity_mode | output | 2 | Raw parity mode field |
| cfg_parity_en | output | 1 | Parity generation and check enabled |
| cfg_parity_odd | output | 1 | Odd parity selected |
| cfg_two_stop | output | 1 | Two stop bits |
| cfg_size_lo | output | 2 | Character-size low bits |
| cfg_clk_pol | output | 1 | Clock polarity |
| cfg_data_bits | output | 4 | Decoded data-bit count, 5 to 9 |
| cfg_error | output | 1 | Reserved size code in use |
| div_hi | output | DIV_HI_W | Divisor high bits |

## Verification
A write and a read can hit the shared address in the same cycle, and that collision leads to ST_WR_RD. The bench provokes the collision in two ways. It does a control write together with a control read, and it does a divisor write together with a qualified divisor read. The scoreboard expects the read to return the contents from before the write. A follow-up read and the configuration outputs must then show that the write took effect. As a second check, the bench watches that a divisor write during this collision leaves every control output unchanged.

// File: rtl/scfg_pkg.sv
package scfg_pkg;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_WR_CTRL = 3'd1,
        ST_WR_DIV  = 3'd2,
        ST_RD_CTRL = 3'd3,
        ST_RD_DIV  = 3'd4,
        ST_WR_RD   = 3'd5
    } acc_state_t;

    // Field order matches the bus bit positions 6..0.
    typedef struct packed {
        logic       sync_mode;
        logic [1:0] parity;
        logic       two_stop;
        logic [1:0] size_lo;
        logic       clk_pol;
    } frame_cfg_t;

    localparam frame_cfg_t FRAME_CFG_RESET = '{
        sync_mode: 1'b0,
        parity:    2'b00,
        two_stop:  1'b0,
        size_lo:   2'b11,
        clk_pol:   1'b0
    };

    localparam int REG_W   = 8;
    localparam int SEL_BIT = REG_W - 1;

endpackage

// File: rtl/scfg_access_fsm.sv
module scfg_access_fsm
    import scfg_pkg::*;
#(
    parameter int              ADDR_W      = 6,
    parameter logic [ADDR_W-1:0] SHARED_ADDR = 6'h20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic              sel_bit,
    input  logic              div_qual,
    output logic              ctrl_we,
    output logic              div_we,
    output logic              rd_take,
    output logic              rd_div,
    output logic              rd_valid
);

    acc_state_t state_q, state_d;
    logic       hit;

    assign hit = (addr == SHARED_ADDR);

    // Next-state classification of the current bus cycle.
    always_comb begin
        state_d = ST_IDLE;
        if (hit && wr_en && rd_en) begin
            state_d = ST_WR_RD;
        end else if (hit && wr_en) begin
            state_d = sel_bit ? ST_WR_CTRL : ST_WR_DIV;
        end else if (hit && rd_en) begin
            state_d = div_qual ? ST_RD_DIV : ST_RD_CTRL;
        end
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Strobes act at the edge that enters the state.
    always_comb begin
        ctrl_we = 1'b0;
        div_we  = 1'b0;
        rd_take = 1'b0;
        rd_div  = div_qual;
        unique case (state_d)
            ST_IDLE:    ;
            ST_WR_CTRL: ctrl_we = 1'b1;
            ST_WR_DIV:  div_we  = 1'b1;
            ST_RD_CTRL: rd_take = 1'b1;
            ST_RD_DIV:  rd_take = 1'b1;
            ST_WR_RD: begin
                rd_take = 1'b1;
                ctrl_we = sel_bit;
                div_we  = !sel_bit;
            end
            default: ;
        endcase
    end

    // Outputs decoded from the registered state.
    always_comb begin
        unique case (state_q)
            ST_RD_CTRL, ST_RD_DIV, ST_WR_RD: rd_valid = 1'b1;
            default:                         rd_valid = 1'b0;
        endcase
    end

endmodule

// File: rtl/scfg_regs.sv
module scfg_regs
    import scfg_pkg::*;
#(
    parameter int DIV_HI_W = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [REG_W-1:0]    wdata,
    input  logic                ctrl_we,
    input  logic                div_we,
    input  logic                rd_take,
    input  logic                rd_div,
    output frame_cfg_t          ctrl,
    output logic [DIV_HI_W-1:0] div_q,
    output logic [REG_W-1:0]    rdata
);

    localparam int PAD_W = REG_W - DIV_HI_W;

    frame_cfg_t          ctrl_q;
    logic [DIV_HI_W-1:0] div_r;
    logic [REG_W-1:0]    rdata_q;
    logic [REG_W-1:0]    rd_mux;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       ctrl_q <= FRAME_CFG_RESET;
        else if (ctrl_we) ctrl_q <= frame_cfg_t'(wdata[SEL_BIT-1:0]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      div_r <= '0;
        else if (div_we) div_r <= wdata[DIV_HI_W-1:0];
    end

    // Select bit reads back as one; unused divisor bits read as zero.
    always_comb begin
        if (rd_div) rd_mux = {{PAD_W{1'b0}}, div_r};
        else        rd_mux = {1'b1, ctrl_q};
    end

    // Capture the value before a same-cycle write.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       rdata_q <= '0;
        else if (rd_take) rdata_q <= rd_mux;
    end

    assign ctrl  = ctrl_q;
    assign div_q = div_r;
    assign rdata = rdata_q;

endmodule

// File: rtl/scfg_size_decode.sv
module scfg_size_decode (
    input  logic       size_hi,
    input  logic [1:0] size_lo,
    output logic [3:0] data_bits,
    output logic       reserved
);

    logic [2:0] code;
    assign code = {size_hi, size_lo};

    always_comb begin
        reserved  = 1'b0;
        data_bits = 4'd8;
        unique case (code)
            3'b000: data_bits = 4'd5;
            3'b001: data_bits = 4'd6;
            3'b010: data_bits = 4'd7;
            3'b011: data_bits = 4'd8;
            3'b111: data_bits = 4'd9;
            default: reserved = 1'b1;
        endcase
    end

endmodule

// File: rtl/scfg_shared_reg.sv
module scfg_shared_reg
    import scfg_pkg::*;
#(
    parameter int                ADDR_W      = 6,
    parameter logic [ADDR_W-1:0] SHARED_ADDR = 6'h20,
    parameter int                DIV_HI_W    = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic                bus_wr,
    input  logic                bus_rd,
    input  logic [7:0]          bus_wdata,
    input  logic                div_rd_qual,
    input  logic                size_hi,
    output logic [7:0]          bus_rdata,
    output logic                bus_rvalid,
    output logic                cfg_sync_mode,
    output logic [1:0]          cfg_parity_mode,
    output logic                cfg_parity_en,
    output logic                cfg_parity_odd,
    output logic                cfg_two_stop,
    output logic [1:0]          cfg_size_lo,
    output logic                cfg_clk_pol,
    output logic [3:0]          cfg_data_bits,
    output logic                cfg_error,
    output logic [DIV_HI_W-1:0] div_hi
);

    logic       ctrl_we, div_we, rd_take, rd_div;
    frame_cfg_t ctrl;

    scfg_access_fsm #(
        .ADDR_W      (ADDR_W),
        .SHARED_ADDR (SHARED_ADDR)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .addr     (bus_addr),
        .wr_en    (bus_wr),
        .rd_en    (bus_rd),
        .sel_bit  (bus_wdata[SEL_BIT]),
        .div_qual (div_rd_qual),
        .ctrl_we  (ctrl_we),
        .div_we   (div_we),
        .rd_take  (rd_take),
        .rd_div   (rd_div),
        .rd_valid (bus_rvalid)
    );

    scfg_regs #(
        .DIV_HI_W (DIV_HI_W)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wdata   (bus_wdata),
        .ctrl_we (ctrl_we),
        .div_we  (div_we),
        .rd_take (rd_take),
        .rd_div  (rd_div),
        .ctrl    (ctrl),
        .div_q   (div_hi),
        .rdata   (bus_rdata)
    );

    scfg_size_decode u_size (
        .size_hi   (size_hi),
        .size_lo   (ctrl.size_lo),
        .data_bits (cfg_data_bits),
        .reserved  (cfg_error)
    );

    // Parity: 10 even, 11 odd, 00 and reserved 01 disabled.
    assign cfg_parity_en   = ctrl.parity[1];
    assign cfg_parity_odd  = ctrl.parity[1] & ctrl.parity[0];
    assign cfg_parity_mode = ctrl.parity;
    assign cfg_sync_mode   = ctrl.sync_mode;
    assign cfg_two_stop    = ctrl.two_stop;
    assign cfg_size_lo     = ctrl.size_lo;
    assign cfg_clk_pol     = ctrl.clk_pol;

endmodule

// File: rtl/scfg_shared_reg_chk.sv
module scfg_shared_reg_chk #(
    parameter int                ADDR_W      = 6,
    parameter logic [ADDR_W-1:0] SHARED_ADDR = 6'h20,
    parameter int                DIV_HI_W    = 4
) (
    input logic                clk,
    input logic                rst_n,
    input logic [ADDR_W-1:0]   bus_addr,
    input logic                bus_wr,
    input logic                bus_rd,
    input logic [7:0]          bus_wdata,
    input logic                div_rd_qual,
    input logic [7:0]          bus_rdata,
    input logic                bus_rvalid,
    input logic                cfg_sync_mode,
    input logic [1:0]          cfg_parity_mode,
    input logic                cfg_two_stop,
    input logic [1:0]          cfg_size_lo,
    input logic                cfg_clk_pol,
    input logic [3:0]          cfg_data_bits,
    input logic                cfg_error,
    input logic [DIV_HI_W-1:0] div_hi
);

    logic hit;
    logic [6:0] fields;
    assign hit    = (bus_addr == SHARED_ADDR);
    assign fields = {cfg_sync_mode, cfg_parity_mode, cfg_two_stop, cfg_size_lo, cfg_clk_pol};

    a_r1_ctrl_write: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && bus_wr && bus_wdata[7]) |=> (fields == $past(bus_wdata[6:0])) && $stable(div_hi));

    a_r2_div_write: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && bus_wr && !bus_wdata[7]) |=> (div_hi == $past(bus_wdata[DIV_HI_W-1:0])) && $stable(fields));

    a_r4_ctrl_read_msb: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && bus_rd && !div_rd_qual) |=> bus_rvalid && bus_rdata[7]);

    a_r5_div_read_pad: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && bus_rd && div_rd_qual) |=> bus_rvalid && (bus_rdata[7:DIV_HI_W] == '0));

    a_r6_miss_no_valid: assert property (@(posedge clk) disable iff (!rst_n)
        !(hit && bus_rd) |=> !bus_rvalid);

    a_r6_miss_no_update: assert property (@(posedge clk) disable iff (!rst_n)
        !(hit && bus_wr) |=> $stable(fields) && $stable(div_hi));

    a_r7_bits_range: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_error |-> (cfg_data_bits >= 4'd5) && (cfg_data_bits <= 4'd9));

    a_r8_reserved_eight: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_error |-> (cfg_data_bits == 4'd8));

    a_r10_collision_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && bus_wr && bus_rd) |=> bus_rvalid);

endmodule

bind scfg_shared_reg scfg_shared_reg_chk #(
    .ADDR_W      (ADDR_W),
    .SHARED_ADDR (SHARED_ADDR),
    .DIV_HI_W    (DIV_HI_W)
) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .bus_addr        (bus_addr),
    .bus_wr          (bus_wr),
    .bus_rd          (bus_rd),
    .bus_wdata       (bus_wdata),
    .div_rd_qual     (div_rd_qual),
    .bus_rdata       (bus_rdata),
    .bus_rvalid      (bus_rvalid),
    .cfg_sync_mode   (cfg_sync_mode),
    .cfg_parity_mode (cfg_parity_mode),
    .cfg_two_stop    (cfg_two_stop),
    .cfg_size_lo     (cfg_size_lo),
    .cfg_clk_pol     (cfg_clk_pol),
    .cfg_data_bits   (cfg_data_bits),
    .cfg_error       (cfg_error),
    .div_hi          (div_hi)
);

// File: tb/sim_scfg_shared_reg.sv
module sim_scfg_shared_reg;

    localparam int         CLK_PERIOD = 10;
    localparam logic [5:0] SHARED     = 6'h20;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [5:0] bus_addr = '0;
    logic       bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic       div_rd_qual = 1'b0, size_hi = 1'b0;
    logic [7:0] bus_rdata;
    logic       bus_rvalid, cfg_sync_mode, cfg_parity_en, cfg_parity_odd;
    logic       cfg_two_stop, cfg_clk_pol, cfg_error;
    logic [1:0] cfg_parity_mode, cfg_size_lo;
    logic [3:0] cfg_data_bits, div_hi;

    int checks = 0;
    int errors = 0;

    logic [6:0] m_ctrl = 7'b0000110;
    logic [3:0] m_div  = 4'h0;
    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    scfg_shared_reg u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .div_rd_qual(div_rd_qual),
        .size_hi(size_hi), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
        .cfg_sync_mode(cfg_sync_mode), .cfg_parity_mode(cfg_parity_mode),
        .cfg_parity_en(cfg_parity_en), .cfg_parity_odd(cfg_parity_odd),
        .cfg_two_stop(cfg_two_stop), .cfg_size_lo(cfg_size_lo),
        .cfg_clk_pol(cfg_clk_pol), .cfg_data_bits(cfg_data_bits),
        .cfg_error(cfg_error), .div_hi(div_hi)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // Monitor: pops the scoreboard whenever read data is presented.
    always @(negedge clk) begin
        if (rst_n && bus_rvalid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R6 unexpected rvalid", 1, 0);
            end else begin
                automatic logic [7:0] e = exp_q.pop_front();
                automatic string      t = tag_q.pop_front();
                check(bus_rdata == e, t, bus_rdata, e);
            end
        end
    end

    task automatic check_cfg(input string tag);
        automatic logic [6:0] act = {cfg_sync_mode, cfg_parity_mode, cfg_two_stop,
                                     cfg_size_lo, cfg_clk_pol};
        check(act == m_ctrl, {tag, " ctrl fields"}, act, m_ctrl);
        check(div_hi == m_div, {tag, " div_hi"}, div_hi, m_div);
    endtask

    function automatic logic [7:0] model_read(input logic q);
        return q ? {4'h0, m_div} : {1'b1, m_ctrl};
    endfunction

    task automatic model_write(input logic [5:0] a, input logic [7:0] d);
        if (a == SHARED) begin
            if (d[7]) m_ctrl = d[6:0];
            else      m_div  = d[3:0];
        end
    endtask

    task automatic do_write(input logic [5:0] a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        model_write(a, d);
    endtask

    task automatic do_read(input logic [5:0] a, input logic q, input string tag);
        if (a == SHARED) begin
            exp_q.push_back(model_read(q));
            tag_q.push_back(tag);
        end
        bus_addr = a; div_rd_qual = q; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0; div_rd_qual = 1'b0;
        @(negedge clk);
    endtask

    task automatic do_wr_rd(input logic [7:0] d, input logic q, input string tag);
        exp_q.push_back(model_read(q));
        tag_q.push_back(tag);
        bus_addr = SHARED; bus_wdata = d; div_rd_qual = q;
        bus_wr = 1'b1; bus_rd = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; bus_rd = 1'b0; div_rd_qual = 1'b0;
        model_write(SHARED, d);
        @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired actual=0x0 expected=0x1");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R3 reset state
        check_cfg("R3 reset");
        check(bus_rvalid == 1'b0, "R3 rvalid low", bus_rvalid, 0);
        check(cfg_data_bits == 4'd8, "R3 default 8 bits", cfg_data_bits, 8);
        do_read(SHARED, 1'b0, "R3 reset read 0x86");

        // R1 control write
        do_write(SHARED, 8'hD5);
        check_cfg("R1 ctrl write");
        do_read(SHARED, 1'b0, "R4 ctrl readback");
        do_write(SHARED, 8'hAA);
        check_cfg("R1 second pattern");

        // R2 divisor write, upper bits dropped
        do_write(SHARED, 8'h7B);
        check_cfg("R2 div write");
        do_read(SHARED, 1'b1, "R5 div readback pad");
        do_read(SHARED, 1'b0, "R4 ctrl after div write");

        // R6 other addresses
        do_write(6'h21, 8'hFF);
        check_cfg("R6 miss ctrl write");
        do_write(6'h00, 8'h05);
        check_cfg("R6 miss div write");
        do_read(6'h1F, 1'b0, "R6 miss read");
        check(exp_q.size() == 0, "R6 no pending reads", exp_q.size(), 0);

        // R9 parity modes
        for (int p = 0; p < 4; p++) begin
            do_write(SHARED, 8'h80 | 8'(p << 4));
            check(cfg_parity_en == (p >= 2), "R9 parity enable", cfg_parity_en, (p >= 2));
            check(cfg_parity_odd == (p == 3), "R9 parity odd", cfg_parity_odd, (p == 3));
        end

        // R7 and R8 size codes
        for (int c = 0; c < 8; c++) begin
            automatic int eb  = (c < 4) ? 5 + c : ((c == 7) ? 9 : 8);
            automatic bit err = (c >= 4) && (c <= 6);
            size_hi = c[2];
            do_write(SHARED, 8'h80 | 8'(c[1:0] << 1));
            if (err) begin
                check(cfg_data_bits == 4'(eb), "R8 reserved bits", cfg_data_bits, eb);
                check(cfg_error == 1'b1, "R8 error flag", cfg_error, 1);
            end else begin
                check(cfg_data_bits == 4'(eb), "R7 data bits", cfg_data_bits, eb);
                check(cfg_error == 1'b0, "R7 no error", cfg_error, 0);
            end
        end
        size_hi = 1'b0;

        // R10 collisions
        do_wr_rd(8'hC9, 1'b0, "R10 ctrl collision old value");
        check_cfg("R10 ctrl write landed");
        do_read(SHARED, 1'b0, "R10 ctrl new value");
        do_wr_rd(8'h03, 1'b1, "R10 div collision old value");
        check_cfg("R10 div write landed, ctrl stable");
        do_read(SHARED, 1'b1, "R10 div new value");

        repeat (2) @(negedge clk);
        check(exp_q.size() == 0, "R4 all reads returned", exp_q.size(), 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule